// File: doc/BRIEF.md
# Sixteen-line GPIO with per-pin interrupt styles

This block drives and samples sixteen general-purpose pins through a small word-wide register port. Software chooses for each pin whether the block drives it or leaves it as an input, and sets the level the block drives. It can read back the pin state after synchronisation, and it can arm an interrupt on the pin. Each pin's interrupt condition comes from a three-bit style field: a high level, a low level, a rising edge, a falling edge, or either edge. The remaining codes switch detection off for that pin.

Each pin latches its condition into a status bit, and that bit is wired out as the pin's interrupt line to an external interrupt controller. Software clears a status bit by writing a 1 to it. A level condition that is still present sets the bit again at once, so a level interrupt cannot be dismissed until its cause goes away. The block has an asynchronous active-low reset whose release is synchronised inside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), pin_out is 0, the status register is 0, every style field holds 7 (detection off), and no irq line is high.
- R2: The direction register (address 1) holds one bit per pin. A 1 makes the pin an input with pin_oe low. A 0 sets pin_oe high, and pin_out then carries the matching bit of the output data register (address 0). Both registers read back as written.
- R3: The input register (address 2, read-only; writes are ignored) returns each pin's sampled state, settled within 4 clocks of a change. The sampled source is pin_in for an input pin and the driven pin_out bit for an output pin.
- R4: Pins 0 to 7 take their style from address 3, and pins 8 to 15 take theirs from address 4. Pin p uses bits 3k+2:3k of its register, with k = p mod 8, and bits 31:24 read 0. The codes are: 0 high level, 1 low level, 2 rising edge, 3 falling edge, 4 either edge, 5 to 7 off.
- R5: A pin with an edge style sets its status bit when its sampled value makes the selected transition. A change in the other direction, or on a pin whose style is off, leaves the status bit unchanged.
- R6: A pin with a level style has its status bit set whenever its sampled value matches the level. This includes the case where a style write makes an already present level qualify.
- R7: Writing address 5 clears each status bit whose data bit is 1 and leaves the others unchanged. A level-style bit whose condition still holds reads 1 again after the clear.
- R8: Each irq output equals the pin's status bit as read at address 5.
- R9: A status bit never falls except through a clear write. It stays set after the pin returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pad input values |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables, 1 = drive |
| irq | output | 16 | Per-pin interrupt lines |

## Verification
The bench builds the block with its default parameters: sixteen pins in two groups of eight, with three-bit style fields. This exercises both style registers and the unused top bits of each, and it covers the full set of eight style codes, including the three that switch detection off. Random mixes of pin changes, style writes, direction changes and clears are checked against a model of the latched status. Directed cases cover a level that survives a clear, both directions of an either-edge style, and a pin in output mode that feeds its own detector.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned STY_W = 3;
  localparam int unsigned ADR_W = 3;

  typedef enum logic [STY_W-1:0] {
    STY_HIGH = 3'd0,
    STY_LOW  = 3'd1,
    STY_RISE = 3'd2,
    STY_FALL = 3'd3,
    STY_BOTH = 3'd4,
    STY_OFF  = 3'd7
  } style_e;

  localparam logic [ADR_W-1:0] A_DOUT  = 3'd0;
  localparam logic [ADR_W-1:0] A_DIR   = 3'd1;
  localparam logic [ADR_W-1:0] A_INP   = 3'd2;
  localparam logic [ADR_W-1:0] A_STY0  = 3'd3;
  localparam logic [ADR_W-1:0] A_STY1  = 3'd4;
  localparam logic [ADR_W-1:0] A_STAT  = 3'd5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] s1_q, s2_q, s3_q;
  logic [N-1:0] s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = raw;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign cur  = s2_q;
  assign prev = s3_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_pkg::*;
(
  input  logic [STY_W-1:0] style,
  input  logic             cur,
  input  logic             prev,
  output logic             hit
);
  always_comb begin
    case (style)
      STY_HIGH: hit = cur;
      STY_LOW:  hit = ~cur;
      STY_RISE: hit = cur & ~prev;
      STY_FALL: hit = ~cur & prev;
      STY_BOTH: hit = cur ^ prev;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter int unsigned GRP  = 8,
  parameter int unsigned DW   = 32,
  localparam int unsigned SFW = GRP * STY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ADR_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  input  logic [N-1:0]     hit,
  input  logic [N-1:0]     sampled,
  output logic [DW-1:0]    rdata,
  output logic [N-1:0]     dout,
  output logic [N-1:0]     dir,
  output logic [SFW-1:0]   sty0,
  output logic [SFW-1:0]   sty1,
  output logic [N-1:0]     status
);
  logic           en_dout, en_dir, en_s0, en_s1, en_clr;
  logic [N-1:0]   dout_d, dir_d, stat_d, clr_mask;
  logic [SFW-1:0] s0_d, s1_d;

  always_comb begin
    en_dout  = wr && (addr == A_DOUT);
    en_dir   = wr && (addr == A_DIR);
    en_s0    = wr && (addr == A_STY0);
    en_s1    = wr && (addr == A_STY1);
    en_clr   = wr && (addr == A_STAT);
    clr_mask = en_clr ? wdata[N-1:0] : '0;
    dout_d   = en_dout ? wdata[N-1:0] : dout;
    dir_d    = en_dir  ? wdata[N-1:0] : dir;
    s0_d     = en_s0   ? wdata[SFW-1:0] : sty0;
    s1_d     = en_s1   ? wdata[SFW-1:0] : sty1;
    stat_d   = hit | (status & ~clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout   <= '0;
      dir    <= '1;
      sty0   <= '1;
      sty1   <= '1;
      status <= '0;
    end else begin
      dout   <= dout_d;
      dir    <= dir_d;
      sty0   <= s0_d;
      sty1   <= s1_d;
      status <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DOUT: rdata[N-1:0]   = dout;
      A_DIR:  rdata[N-1:0]   = dir;
      A_INP:  rdata[N-1:0]   = sampled;
      A_STY0: rdata[SFW-1:0] = sty0;
      A_STY1: rdata[SFW-1:0] = sty1;
      A_STAT: rdata[N-1:0]   = status;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned N   = 16,
  parameter int unsigned GRP = 8,
  parameter int unsigned DW  = 32,
  localparam int unsigned SFW = GRP * STY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N-1:0]     pin_in,
  output logic [N-1:0]     pin_out,
  output logic [N-1:0]     pin_oe,
  output logic [N-1:0]     irq
);
  logic           rst_a_q, rst_q;
  logic [N-1:0]   dout, dir, status, hit, cur, prev, pad_src;
  logic [SFW-1:0] sty0, sty1;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_q   <= rst_a_q;
    end
  end

  assign pad_src = (pin_in & dir) | (dout & ~dir);

  gpio_sync #(.N(N)) u_sync (
    .clk (clk), .rst_n (rst_q), .raw (pad_src), .cur (cur), .prev (prev)
  );

  for (genvar p = 0; p < N; p++) begin : g_pin
    localparam int unsigned OFS = (p % GRP) * STY_W;
    logic [STY_W-1:0] sty;
    if (p < GRP) begin : g_lo
      assign sty = sty0[OFS +: STY_W];
    end else begin : g_hi
      assign sty = sty1[OFS +: STY_W];
    end
    gpio_detect u_det (
      .style (sty), .cur (cur[p]), .prev (prev[p]), .hit (hit[p])
    );
  end

  gpio_regs #(.N(N), .GRP(GRP), .DW(DW)) u_regs (
    .clk (clk), .rst_n (rst_q), .wr (bus_wr), .addr (bus_addr),
    .wdata (bus_wdata), .hit (hit), .sampled (cur), .rdata (bus_rdata),
    .dout (dout), .dir (dir), .sty0 (sty0), .sty1 (sty1), .status (status)
  );

  assign pin_out = dout;
  assign pin_oe  = ~dir;
  assign irq     = status;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned DW = 32
) (
  input logic             clk,
  input logic             rst_q,
  input logic             bus_wr,
  input logic [ADR_W-1:0] bus_addr,
  input logic [DW-1:0]    bus_rdata,
  input logic [N-1:0]     pin_in,
  input logic [N-1:0]     pin_out,
  input logic [N-1:0]     pin_oe,
  input logic [N-1:0]     irq,
  input logic [N-1:0]     cur
);
  logic [1:0]   cyc;
  logic [N-1:0] eff;
  assign eff = (pin_in & ~pin_oe) | (pin_out & pin_oe);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_wr && bus_addr == A_DOUT) |=> $stable(pin_out));

  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_wr && bus_addr == A_DIR) |=> $stable(pin_oe));

  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_wr && bus_addr == A_STAT) |=> ((irq & $past(irq)) == $past(irq)));

  a_r3_sync_latency: assert property (@(posedge clk) disable iff (!rst_q)
    (cyc == 2'd3) |-> (cur == $past(eff, 2)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N), .DW(DW)) u_chk (
  .clk (clk), .rst_q (rst_q), .bus_wr (bus_wr), .bus_addr (bus_addr),
  .bus_rdata (bus_rdata), .pin_in (pin_in), .pin_out (pin_out),
  .pin_oe (pin_oe), .irq (irq), .cur (cur)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, irq;

  int nchk = 0;
  int nbad = 0;

  logic [2:0]  m_sty [16];
  logic [15:0] m_dout, m_dir, m_stat, m_eff;

  gpio_irq_ctrl u0 (.*);

  always #2.5 clk = ~clk;

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic lvl(logic [2:0] s, logic v);
    return (s == 3'd0 && v) || (s == 3'd1 && !v);
  endfunction

  function automatic logic edg(logic [2:0] s, logic o, logic n);
    return (s == 3'd2 && !o && n) || (s == 3'd3 && o && !n) || (s == 3'd4 && o != n);
  endfunction

  function automatic logic [15:0] eff_of(logic [15:0] pi, logic [15:0] d, logic [15:0] dr);
    return (pi & dr) | (d & ~dr);
  endfunction

  function automatic logic [31:0] sty_word(int g);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w[3*k +: 3] = m_sty[g*8+k];
    return w;
  endfunction

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // update model with a new effective pad vector
  task automatic model_eff(logic [15:0] ne);
    for (int p = 0; p < 16; p++)
      if (edg(m_sty[p], m_eff[p], ne[p]) || lvl(m_sty[p], ne[p])) m_stat[p] = 1'b1;
    m_eff = ne;
  endtask

  task automatic model_lvl();
    for (int p = 0; p < 16; p++) if (lvl(m_sty[p], m_eff[p])) m_stat[p] = 1'b1;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    model_eff(eff_of(v, m_dout, m_dir));
    settle();
  endtask

  task automatic w_style(int g, logic [31:0] w);
    for (int k = 0; k < 8; k++) m_sty[g*8+k] = w[3*k +: 3];
    wr(g == 0 ? 3'd3 : 3'd4, w);
    model_lvl();
    settle();
  endtask

  task automatic w_clear(logic [15:0] m);
    wr(3'd5, {16'h0, m});
    m_stat = m_stat & ~m;
    model_lvl();
    settle();
  endtask

  task automatic w_dirout(logic [15:0] d, logic [15:0] dr);
    wr(3'd0, {16'h0, d});
    m_dout = d;
    model_eff(eff_of(pin_in, m_dout, m_dir));
    settle();
    wr(3'd1, {16'h0, dr});
    m_dir = dr;
    model_eff(eff_of(pin_in, m_dout, m_dir));
    settle();
  endtask

  task automatic check_all(string ctx);
    logic [31:0] r;
    rd(3'd2, r); chk({ctx, " R3 input"}, r, {16'h0, m_eff});
    rd(3'd5, r); chk({ctx, " R7 status"}, r, {16'h0, m_stat});
    chk({ctx, " R8 irq"}, {16'h0, irq}, {16'h0, m_stat});
    chk({ctx, " R2 pin_oe"}, {16'h0, pin_oe}, {16'h0, ~m_dir});
    chk({ctx, " R2 pin_out"}, {16'h0, pin_out}, {16'h0, m_dout});
    rd(3'd3, r); chk({ctx, " R4 style0"}, r, sty_word(0));
    rd(3'd4, r); chk({ctx, " R4 style1"}, r, sty_word(1));
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] w;
    void'($urandom(32'h5eed1234));
    for (int p = 0; p < 16; p++) m_sty[p] = 3'd7;
    m_dout = '0; m_dir = '1; m_stat = '0; m_eff = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset values
    rd(3'd1, r); chk("R1 dir reset", r, 32'h0000ffff);
    rd(3'd0, r); chk("R1 dout reset", r, 32'h0);
    rd(3'd3, r); chk("R1 style0 reset", r, 32'h00ffffff);
    rd(3'd4, r); chk("R1 style1 reset", r, 32'h00ffffff);
    chk("R1 irq reset", {16'h0, irq}, 32'h0);
    chk("R1 pin_oe reset", {16'h0, pin_oe}, 32'h0);

    // R3 writes to input register ignored
    set_pins(16'h00a5);
    wr(3'd2, 32'h0000ffff);
    settle();
    check_all("R3 ignore");

    // R6/R7: active-high on pin 0 stays set across clear
    w_style(0, 32'h00fffff8);
    check_all("R6 level");
    w_clear(16'h0001);
    rd(3'd5, r); chk("R7 level reasserts", r & 32'h1, 32'h1);
    set_pins(16'h00a4);
    w_clear(16'h0001);
    rd(3'd5, r); chk("R7 clear after level gone", r & 32'h1, 32'h0);

    // R5 both edges on pin 9 (field k=1 of group 1)
    w_style(1, 32'h00ffffe7);
    set_pins(16'h02a4);
    rd(3'd5, r); chk("R5 both rise", r & 32'h200, 32'h200);
    w_clear(16'h0200);
    set_pins(16'h00a4);
    rd(3'd5, r); chk("R5 both fall", r & 32'h200, 32'h200);
    w_clear(16'h0200);
    // R9 edge status remains after pin idles
    set_pins(16'h02a4);
    set_pins(16'h00a4);
    rd(3'd5, r); chk("R9 sticky", r & 32'h200, 32'h200);
    w_clear(16'hffff);
    check_all("R7 full clear");

    // R3/R5: output-mode pin 9 feeds its own detector
    w_dirout(16'h0200, 16'hfdff);
    check_all("R3 output loop");
    w_clear(16'hffff);

    // random mix
    for (int it = 0; it < 120; it++) begin
      case ($urandom % 4)
        0: set_pins(16'($urandom));
        1: begin
          w = '0;
          for (int k = 0; k < 8; k++) w[3*k +: 3] = 3'($urandom);
          w_style(int'($urandom % 2), w);
        end
        2: w_clear(16'($urandom));
        default: w_dirout(16'($urandom), 16'($urandom) | 16'hf0f0);
      endcase
      check_all("rnd");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule